// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block moves data for one DMA channel. Software first loads a transfer descriptor through a small word-write port. The descriptor gives the source and destination addresses, a signed step for each, the beat size on each side, a modulo window for each address, the number of bytes per service request, an iteration count, and signed address corrections applied after the last iteration. A service request starts one inner loop. It can come from a software start command or from a hardware request line. The engine then reads and writes the inner byte count over a single-outstanding memory bus. When source and destination sizes differ, it packs or unpacks the data through a 32-bit staging word.

Each finished inner loop decrements the current iteration count. A one-cycle interrupt pulse is raised when the count passes its half-way point. When the count reaches zero, the engine adds the end corrections, reloads the count, sets a done flag and can pulse a completion interrupt. A done channel can be set to ignore the hardware request line. Bad descriptors are refused and flagged.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `active`, `done`, `cfgErr`, `memReq`, `intHalf` and `intMajor` are all 0.
- R2: Descriptor word writes (`cfgAddr`) are taken only while `active` is 0. Word 0 is the source address. Word 1 is the destination address. Word 2 holds the source step in bits 31:16 and the destination step in bits 15:0, both signed. Word 3 is the inner byte count. Word 4 is the source end correction and word 5 the destination end correction, both signed 32-bit. Word 6 holds the source size code in bits 2:0, the destination size code in bits 6:4, the source modulo in bits 12:8 and the destination modulo in bits 20:16. Word 7 holds the iteration count in bits 14:0, the half-way interrupt enable in bit 16, the completion interrupt enable in bit 17 and the ignore-request-when-done bit in bit 18. Writing word 7 also reloads the current count and clears `done`. A write while `active` is 1 changes nothing.
- R3: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes, and `memSize` carries the code of the current beat. Let L be the larger of the two sizes. Each block of L bytes is moved as L/source-size reads followed by L/destination-size writes. Bus data is right-aligned, and read data is packed little-endian (first read in the lowest bytes). The inner loop is repeated until the inner byte count has moved.
- R4: Each request holds its address, direction and size steady until `memAck`. After each read beat the source address advances by its signed step. After each write beat the destination address advances by its signed step.
- R5: A nonzero modulo M keeps address bits 31..M at their current value on every update, so only bits M-1..0 change. M = 0 disables the limit.
- R6: Each finished inner loop decrements the current count. When it reaches zero, the source and destination end corrections are added (under modulo), the count reloads from the iteration count, and `done` becomes 1 while `active` falls.
- R7: `intHalf` pulses for one cycle at the end of an inner loop whose new count equals the iteration count shifted right by one, provided the half-way enable is set.
- R8: `intMajor` pulses for one cycle when the count reaches zero, provided the completion enable is set.
- R9: Writing word 8 with bit 0 set while idle starts one inner loop. `active` is 1 from the next cycle until the loop ends.
- R10: A high `hwReq` while idle starts one inner loop, unless `done` is 1 and the ignore bit is set, in which case it is ignored. Every accepted start clears `done`.
- R11: A start is refused when a size code is above 2, the inner count is 0 or not a multiple of L, or the iteration count is 0. A refused start moves no data, leaves `active` at 0 and sets `cfgErr`. `cfgErr` stays set until the next accepted start.
- R12: Reset leaves the descriptor, the current addresses and the current count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Descriptor word write strobe |
| cfgAddr | input | 4 | Descriptor word index (0..7), 8 = start command |
| cfgWdata | input | 32 | Descriptor write data |
| hwReq | input | 1 | Hardware service request |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | ADDR_W | Beat byte address |
| memSize | output | 2 | Beat size code |
| memWdata | output | 32 | Write data, right-aligned |
| memAck | input | 1 | Beat accepted / read data valid |
| memRdata | input | 32 | Read data, right-aligned |
| active | output | 1 | Channel running an inner loop |
| done | output | 1 | Outer loop completed |
| cfgErr | output | 1 | Last start refused for a bad descriptor |
| intHalf | output | 1 | Half-way interrupt pulse |
| intMajor | output | 1 | Completion interrupt pulse |

## Verification
`active` rises on the clock edge that samples the start command or `hwReq`. The first request appears in the same cycle. Each beat completes in the cycle where `memAck` is high, so the write monitor compares address, size and data at the falling edge of that cycle against the scoreboard entry queued before the start. `done`, `intHalf` and `intMajor` change one cycle after the last write's acknowledge, on the same edge that drops `active`. End-of-loop checks therefore wait for `active` to fall and one more falling edge before comparing flags and interrupt counts. Refused and ignored starts are checked at the first falling edge after the sampling edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_STEP} chanState_t;

  typedef struct packed {
    logic beginMinor;
    logic refuseStart;
    logic readBeat;
    logic writeBeat;
    logic finishMinor;
  } ctrlStrobe_t;

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] code);
    case (code)
      2'd0:    laneMask = 32'h0000_00FF;
      2'd1:    laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // last beat index for a block made of 2**diff beats
  function automatic logic [1:0] lastBeat(input logic [1:0] diff);
    lastBeat = {diff[1], |diff};
  endfunction
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swStart,
  input  logic        hwReq,
  input  logic        reqGate,
  input  logic        cfgBad,
  input  logic        lastRd,
  input  logic        lastWr,
  input  logic        lastBlock,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        idle
);
  chanState_t state, stateNext;
  logic goNow;

  assign goNow = swStart || (hwReq && !reqGate);

  always_comb begin
    stateNext = state;
    strobe = '0;
    case (state)
      ST_IDLE: if (goNow) begin
        if (cfgBad) strobe.refuseStart = 1'b1;
        else begin
          strobe.beginMinor = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: if (memAck) begin
        strobe.readBeat = 1'b1;
        if (lastRd) stateNext = ST_WRITE;
      end
      ST_WRITE: if (memAck) begin
        strobe.writeBeat = 1'b1;
        if (lastWr) stateNext = lastBlock ? ST_STEP : ST_READ;
      end
      ST_STEP: begin
        strobe.finishMinor = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign idle   = (state == ST_IDLE);

  // R10: a gated hardware request alone leaves the channel idle
  assert_gated_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idle && hwReq && reqGate && !swStart) |=> idle);

  // R11: a refused start never enters a transfer
  assert_refused_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (idle && goNow && cfgBad) |=> idle);
endmodule

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int ITER_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              idle,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [1:0]        rdCode,
  output logic [1:0]        wrCode,
  output logic [DATA_W-1:0] wrData,
  output logic              lastRd,
  output logic              lastWr,
  output logic              lastBlock,
  output logic              cfgBad,
  output logic              reqGate,
  output logic              done,
  output logic              cfgErr,
  output logic              intHalf,
  output logic              intMajor
);
  localparam int MOD_W = $clog2(ADDR_W);

  // descriptor and running state: deliberately without reset
  logic [ADDR_W-1:0] srcCur, dstCur;
  logic [OFF_W-1:0]  srcOff, dstOff;
  logic [DATA_W-1:0] innerBytes, srcLast, dstLast;
  logic [2:0]        sCode, dCode;
  logic [MOD_W-1:0]  sMod, dMod;
  logic [ITER_W-1:0] startIter, curIter, iterNext;
  logic              halfEn, majEn, disReq;

  logic [DATA_W-1:0] bytesLeft, dataBuf, blkBytes;
  logic [1:0]        rdIdx, wrIdx, lC;
  logic [4:0]        rdShift, wrShift;
  logic [ADDR_W-1:0] srcStep, dstStep;

  function automatic logic [ADDR_W-1:0] wrapAddr(input logic [ADDR_W-1:0] cur,
                                                  input logic [ADDR_W-1:0] sum,
                                                  input logic [MOD_W-1:0]  m);
    logic [ADDR_W-1:0] keep;
    keep = (m == '0) ? '0 : ({ADDR_W{1'b1}} << m);
    return (cur & keep) | (sum & ~keep);
  endfunction

  assign rdCode   = sCode[1:0];
  assign wrCode   = dCode[1:0];
  assign lC       = (rdCode > wrCode) ? rdCode : wrCode;
  assign blkBytes = DATA_W'(1) << lC;
  assign lastRd   = (rdIdx == lastBeat(lC - rdCode));
  assign lastWr   = (wrIdx == lastBeat(lC - wrCode));
  assign lastBlock = (bytesLeft == blkBytes);
  assign rdShift  = {rdIdx, 3'b000} << rdCode;
  assign wrShift  = {wrIdx, 3'b000} << wrCode;
  assign wrData   = (dataBuf >> wrShift) & laneMask(wrCode);
  assign srcStep  = {{(ADDR_W-OFF_W){srcOff[OFF_W-1]}}, srcOff};
  assign dstStep  = {{(ADDR_W-OFF_W){dstOff[OFF_W-1]}}, dstOff};
  assign iterNext = curIter - ITER_W'(1);
  assign srcAddr  = srcCur;
  assign dstAddr  = dstCur;
  assign reqGate  = done && disReq;
  assign cfgBad   = (sCode > 3'd2) || (dCode > 3'd2) || (innerBytes == '0) ||
                    ((innerBytes & (blkBytes - DATA_W'(1))) != '0) || (startIter == '0);

  always_ff @(posedge clk) begin
    if (cfgWe && idle) begin
      case (cfgAddr)
        4'd0: srcCur <= ADDR_W'(cfgWdata);
        4'd1: dstCur <= ADDR_W'(cfgWdata);
        4'd2: begin
          srcOff <= cfgWdata[16 +: OFF_W];
          dstOff <= cfgWdata[0 +: OFF_W];
        end
        4'd3: innerBytes <= cfgWdata;
        4'd4: srcLast <= cfgWdata;
        4'd5: dstLast <= cfgWdata;
        4'd6: begin
          sCode <= cfgWdata[2:0];
          dCode <= cfgWdata[6:4];
          sMod  <= cfgWdata[8 +: MOD_W];
          dMod  <= cfgWdata[16 +: MOD_W];
        end
        4'd7: begin
          startIter <= cfgWdata[ITER_W-1:0];
          curIter   <= cfgWdata[ITER_W-1:0];
          halfEn    <= cfgWdata[16];
          majEn     <= cfgWdata[17];
          disReq    <= cfgWdata[18];
        end
        default: ;
      endcase
    end
    if (strobe.readBeat)  srcCur <= wrapAddr(srcCur, srcCur + srcStep, sMod);
    if (strobe.writeBeat) dstCur <= wrapAddr(dstCur, dstCur + dstStep, dMod);
    if (strobe.finishMinor) begin
      if (iterNext == '0) begin
        srcCur  <= wrapAddr(srcCur, srcCur + ADDR_W'(srcLast), sMod);
        dstCur  <= wrapAddr(dstCur, dstCur + ADDR_W'(dstLast), dMod);
        curIter <= startIter;
      end else begin
        curIter <= iterNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;  cfgErr <= 1'b0;  intHalf <= 1'b0;  intMajor <= 1'b0;
      rdIdx <= '0;   wrIdx <= '0;     bytesLeft <= '0;  dataBuf <= '0;
    end else begin
      intHalf  <= 1'b0;
      intMajor <= 1'b0;
      if (cfgWe && idle && cfgAddr == 4'd7) done <= 1'b0;
      if (strobe.refuseStart) cfgErr <= 1'b1;
      if (strobe.beginMinor) begin
        done <= 1'b0;  cfgErr <= 1'b0;
        bytesLeft <= innerBytes;
        rdIdx <= '0;   wrIdx <= '0;  dataBuf <= '0;
      end
      if (strobe.readBeat) begin
        dataBuf <= dataBuf | ((memRdata & laneMask(rdCode)) << rdShift);
        rdIdx   <= lastRd ? 2'd0 : rdIdx + 2'd1;
      end
      if (strobe.writeBeat) begin
        wrIdx <= lastWr ? 2'd0 : wrIdx + 2'd1;
        if (lastWr) begin
          bytesLeft <= bytesLeft - blkBytes;
          dataBuf   <= '0;
        end
      end
      if (strobe.finishMinor) begin
        intHalf <= halfEn && (iterNext == (startIter >> 1));
        if (iterNext == '0) begin
          done     <= 1'b1;
          intMajor <= majEn;
        end
      end
    end
  end

  // R5: bits at and above the source modulo stay put across a read beat
  assert_src_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readBeat && sMod != '0) |=> (((srcCur ^ $past(srcCur)) >> $past(sMod)) == '0));

  // R8: a completion pulse only comes with done set
  assert_major_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    intMajor |-> done);

  // R6: completion leaves the count reloaded
  assert_reload_on_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (curIter == startIter));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int ITER_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              hwReq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              active,
  output logic              done,
  output logic              cfgErr,
  output logic              intHalf,
  output logic              intMajor
);
  ctrlStrobe_t strobe;
  logic idle, swStart, lastRd, lastWr, lastBlock, cfgBad, reqGate;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [1:0] rdCode, wrCode;

  assign swStart = cfgWe && (cfgAddr == 4'd8) && cfgWdata[0];

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swStart(swStart), .hwReq(hwReq), .reqGate(reqGate),
    .cfgBad(cfgBad), .lastRd(lastRd), .lastWr(lastWr), .lastBlock(lastBlock),
    .memAck(memAck), .strobe(strobe), .memReq(memReq), .memWe(memWe), .idle(idle)
  );

  dma_chan_dpath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ITER_W(ITER_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .idle(idle), .strobe(strobe), .memRdata(memRdata), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .rdCode(rdCode), .wrCode(wrCode), .wrData(memWdata),
    .lastRd(lastRd), .lastWr(lastWr), .lastBlock(lastBlock), .cfgBad(cfgBad),
    .reqGate(reqGate), .done(done), .cfgErr(cfgErr), .intHalf(intHalf),
    .intMajor(intMajor)
  );

  assign active  = !idle;
  assign memAddr = memWe ? dstAddr : srcAddr;
  assign memSize = memWe ? wrCode : rdCode;

  // R4: a pending beat keeps its request, address and direction
  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memSize)));

  // R6: done rises only as the channel goes idle
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !active);

  // R11: a raised error never coincides with a running loop
  assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> !active);
endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, cfgWe, hwReq, memReq, memWe, memAck;
  logic [3:0]  cfgAddr;
  logic [31:0] cfgWdata, memAddr, memWdata, memRdata;
  logic [1:0]  memSize;
  logic        active, done, cfgErr, intHalf, intMajor;

  dma_chan_engine u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .hwReq(hwReq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memSize(memSize), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .active(active), .done(done), .cfgErr(cfgErr), .intHalf(intHalf), .intMajor(intMajor)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
  } wrItem_t;

  logic [7:0] mem [0:255];
  wrItem_t expQ[$];
  int nChecks = 0, nFail = 0;
  int halfCnt = 0, majCnt = 0, expHalf = 0, expMajor = 0;
  bit finished = 0;

  // bench model of the descriptor and channel state
  logic [31:0] mSrc, mDst, cInner, cSlast, cDlast;
  logic [15:0] cSoff, cDoff;
  int cSc, cDc, cSm, cDm, cIter, mIter;
  bit cHalf, cMaj, cDis, mDone;

  function automatic logic [31:0] rdMem(input logic [31:0] a, input int nb);
    logic [31:0] r = '0;
    for (int b = 0; b < nb; b++) r[8*b +: 8] = mem[8'(a + 32'(b))];
    return r;
  endfunction

  function automatic logic [31:0] wrapA(input logic [31:0] cur, input logic [31:0] sum, input int m);
    logic [31:0] keep;
    keep = (m == 0) ? 32'h0 : (32'hFFFF_FFFF << m);
    return (cur & keep) | (sum & ~keep);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic endRun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // memory responder: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) begin
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (b < (1 << memSize)) mem[8'(memAddr + 32'(b))] <= memWdata[8*b +: 8];
        end else begin
          memRdata <= rdMem(memAddr, 1 << memSize);
        end
      end
    end
  end

  // monitor: compare every accepted write against the scoreboard
  always @(negedge clk) begin : monitor
    wrItem_t e;
    if (rstN) begin
      if (intHalf) halfCnt++;
      if (intMajor) majCnt++;
      if (memReq && memAck && memWe) begin
        if (expQ.size() == 0) begin
          nChecks++; nFail++;
          $display("FAIL R3: actual write %h@%h expected none", memWdata, memAddr);
        end else begin
          e = expQ.pop_front();
          check(memAddr == e.addr, "R4 write address", memAddr, e.addr);
          check(memSize == e.size, "R3 write size", 32'(memSize), 32'(e.size));
          check(memWdata == e.data, "R3 write data", memWdata, e.data);
        end
      end
    end
  end

  // driver side: push the writes one inner loop must produce
  task automatic expectMinor();
    int sB, dB, lB;
    logic [31:0] stage;
    wrItem_t it;
    sB = 1 << cSc; dB = 1 << cDc; lB = (sB > dB) ? sB : dB;
    for (int blk = 0; blk < int'(cInner) / lB; blk++) begin
      stage = '0;
      for (int r = 0; r < lB / sB; r++) begin
        stage |= rdMem(mSrc, sB) << (r * sB * 8);
        mSrc = wrapA(mSrc, mSrc + {{16{cSoff[15]}}, cSoff}, cSm);
      end
      for (int w = 0; w < lB / dB; w++) begin
        it.addr = mDst;
        it.size = 2'(cDc);
        it.data = (stage >> (w * dB * 8)) & ((dB == 4) ? 32'hFFFF_FFFF : ((32'h1 << (dB * 8)) - 1));
        expQ.push_back(it);
        mDst = wrapA(mDst, mDst + {{16{cDoff[15]}}, cDoff}, cDm);
      end
    end
    mIter--;
    mDone = 0;
    if (cHalf && mIter == (cIter >> 1)) expHalf++;
    if (mIter == 0) begin
      mSrc = wrapA(mSrc, mSrc + cSlast, cSm);
      mDst = wrapA(mDst, mDst + cDlast, cDm);
      mIter = cIter;
      mDone = 1;
      if (cMaj) expMajor++;
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic configure(input logic [31:0] src, input logic [31:0] dst,
                           input logic [15:0] soff, input logic [15:0] doff,
                           input logic [31:0] inner, input logic [31:0] slast, input logic [31:0] dlast,
                           input int sc, input int dc, input int sm, input int dm,
                           input int iter, input bit he, input bit me, input bit dis);
    logic [31:0] w6, w7;
    w6 = '0; w6[2:0] = 3'(sc); w6[6:4] = 3'(dc); w6[12:8] = 5'(sm); w6[20:16] = 5'(dm);
    w7 = '0; w7[14:0] = 15'(iter); w7[16] = he; w7[17] = me; w7[18] = dis;
    cfgWrite(4'd0, src);  cfgWrite(4'd1, dst);   cfgWrite(4'd2, {soff, doff});
    cfgWrite(4'd3, inner); cfgWrite(4'd4, slast); cfgWrite(4'd5, dlast);
    cfgWrite(4'd6, w6);   cfgWrite(4'd7, w7);
    mSrc = src; mDst = dst; cSoff = soff; cDoff = doff; cInner = inner;
    cSlast = slast; cDlast = dlast; cSc = sc; cDc = dc; cSm = sm; cDm = dm;
    cIter = iter; mIter = iter; cHalf = he; cMaj = me; cDis = dis; mDone = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (active && n < 500) begin @(negedge clk); n++; end
    check(!active, "R9 loop ends", 32'(active), 32'd0);
    @(negedge clk);
  endtask

  // start one loop by software (useHw=0) or hardware request (useHw=1)
  task automatic startCmd(input bit useHw, input bit expectRun, input string req);
    if (expectRun) expectMinor();
    @(negedge clk);
    if (useHw) hwReq = 1'b1;
    else begin cfgWe = 1'b1; cfgAddr = 4'd8; cfgWdata = 32'h1; end
    @(negedge clk);
    hwReq = 1'b0; cfgWe = 1'b0;
    check(active == expectRun, req, 32'(active), 32'(expectRun));
    if (expectRun) begin
      check(done == 1'b0, "R10 start clears done", 32'(done), 32'd0);
      waitIdle();
      check(expQ.size() == 0, "R3 all writes seen", 32'(expQ.size()), 32'd0);
      check(done == mDone, "R6 done flag", 32'(done), 32'(mDone));
      check(halfCnt == expHalf, "R7 half pulses", 32'(halfCnt), 32'(expHalf));
      check(majCnt == expMajor, "R8 completion pulses", 32'(majCnt), 32'(expMajor));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      endRun();
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0; hwReq = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'(i * 7 + 3) : 8'h00;
    repeat (3) @(negedge clk);
    check({active, done, cfgErr, memReq, intHalf, intMajor} == 6'b0, "R1 in reset",
          32'({active, done, cfgErr, memReq, intHalf, intMajor}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({active, done, cfgErr, memReq, intHalf, intMajor} == 6'b0, "R1 after reset",
          32'({active, done, cfgErr, memReq, intHalf, intMajor}), 32'd0);

    // R9 R6 R7 R8: two-iteration outer loop with end corrections, then a reload
    configure(32'h10, 32'h80, 16'd4, 16'd4, 32'd8, -32'sd16, -32'sd16, 2, 2, 0, 0, 2, 1, 1, 0);
    startCmd(0, 1, "R9 software start");
    startCmd(0, 1, "R9 software start");
    startCmd(0, 1, "R6 start after reload");

    // R3: narrow reads packed into words, words unpacked into bytes, negative step
    configure(32'h20, 32'h90, 16'd1, 16'd4, 32'd8, 32'd0, 32'd0, 0, 2, 0, 0, 1, 0, 1, 0);
    startCmd(0, 1, "R3 pack start");
    configure(32'h30, 32'hA0, 16'd4, 16'd1, 32'd4, 32'd0, 32'd0, 2, 0, 0, 0, 1, 0, 1, 0);
    startCmd(0, 1, "R3 unpack start");
    configure(32'h4E, 32'hB0, -16'sd2, 16'd2, 32'd6, 32'd0, 32'd0, 1, 1, 0, 0, 3, 1, 1, 0);
    startCmd(0, 1, "R4 negative step");
    startCmd(0, 1, "R7 half-way of three");
    startCmd(0, 1, "R8 end of three");

    // R5: modulo windows on both sides
    configure(32'h40, 32'hC8, 16'd4, 16'd4, 32'd16, 32'd0, 32'd0, 2, 2, 3, 4, 1, 0, 1, 0);
    startCmd(0, 1, "R5 modulo start");

    // R10: hardware request, then ignored once done with the ignore bit set
    configure(32'h50, 32'hE0, 16'd4, 16'd4, 32'd4, 32'd0, 32'd0, 2, 2, 0, 0, 1, 0, 1, 1);
    startCmd(1, 1, "R10 hardware start");
    startCmd(1, 0, "R10 gated request ignored");
    repeat (4) @(negedge clk);
    check(!active && expQ.size() == 0, "R10 no transfer when gated", 32'(active), 32'd0);
    check(done == 1'b1, "R10 done kept", 32'(done), 32'd1);
    startCmd(0, 1, "R10 software start not gated");
    configure(32'h54, 32'hE8, 16'd4, 16'd4, 32'd4, 32'd0, 32'd0, 2, 2, 0, 0, 1, 0, 1, 0);
    startCmd(1, 1, "R10 ungated request");
    startCmd(1, 1, "R10 request while done, no gate");

    // R11: refused descriptors
    configure(32'h60, 32'hF0, 16'd4, 16'd4, 32'd4, 32'd0, 32'd0, 2, 3, 0, 0, 1, 0, 1, 0);
    startCmd(0, 0, "R11 bad size refused");
    check(cfgErr == 1'b1, "R11 error flag", 32'(cfgErr), 32'd1);
    configure(32'h60, 32'hF0, 16'd4, 16'd4, 32'd6, 32'd0, 32'd0, 2, 2, 0, 0, 1, 0, 1, 0);
    startCmd(0, 0, "R11 ragged count refused");
    check(cfgErr == 1'b1, "R11 error flag", 32'(cfgErr), 32'd1);
    configure(32'h60, 32'hF0, 16'd4, 16'd4, 32'd4, 32'd0, 32'd0, 2, 2, 0, 0, 0, 0, 1, 0);
    startCmd(1, 0, "R11 zero iterations refused");
    check(cfgErr == 1'b1, "R11 error flag", 32'(cfgErr), 32'd1);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && !active, "R11 no transfer", 32'(active), 32'd0);
    configure(32'h60, 32'hF0, 16'd4, 16'd4, 32'd4, 32'd0, 32'd0, 2, 2, 0, 0, 3, 0, 1, 0);
    startCmd(0, 1, "R11 good start");
    check(cfgErr == 1'b0, "R11 error cleared", 32'(cfgErr), 32'd0);

    // R2: descriptor writes during a loop are dropped
    configure(32'h00, 32'hC0, 16'd4, 16'd4, 32'd16, 32'd0, 32'd0, 2, 2, 0, 0, 3, 0, 1, 0);
    expectMinor();
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'd8; cfgWdata = 32'h1;
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'd1; cfgWdata = 32'h0000_0070;
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'd6; cfgWdata = 32'h0000_0000;
    @(negedge clk);
    cfgWe = 1'b0;
    check(active == 1'b1, "R2 still running", 32'(active), 32'd1);
    waitIdle();
    check(expQ.size() == 0, "R2 loop unchanged", 32'(expQ.size()), 32'd0);
    startCmd(0, 1, "R2 descriptor kept");

    // R12: reset keeps the descriptor and position
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({active, done, cfgErr} == 3'b0, "R1 flags after second reset",
          32'({active, done, cfgErr}), 32'd0);
    startCmd(0, 1, "R12 resume after reset");

    endRun();
  end
endmodule